// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date for a real-time clock. Each field sits in its own packed-BCD register: seconds, minutes, hours (24-hour form), day of week, date, month and a two-digit year. A prescaler divides the timebase clock, nominally 32.768 kHz, down to one advance per second. Every advance carries through all fields, following month lengths and a leap-year rule that holds for the years 2000 to 2099.

A host can load any single field at any time. A load takes effect on the next clock edge, and it also restarts the prescaler, so the next second begins at the moment of the load. A freeze input, driven by an event monitor, stops both the prescaler and the registers. The time captured at an event then stays readable until freeze is released. All fields are always driven out, for readout and for alarm comparison.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: While rstN is low, and after it is released, the fields read seconds 00, minutes 00, hours 00, day of week 0, date 01, month 01, year 00.
- R2: With freeze low and no load, seconds advance by one exactly every TICK_DIV timebase cycles. The first advance comes TICK_DIV cycles after reset release or after the last load cycle.
- R3: Seconds and minutes count 00 to 59 in BCD. Seconds wrap from 59 to 00 and carry one minute. Minutes wrap from 59 to 00 and carry one hour.
- R4: Hours count 00 to 23. On the advance from 23:59:59, hours wrap to 00, the date steps, and the day of week steps at the same time.
- R5: Day of week counts 0 to 6 and wraps from 6 to 0.
- R6: April, June, September and November end after day 30. The other months, except February, end after day 31. At a month end the date returns to 01 and the month steps.
- R7: February ends after day 29 when the two-digit year is divisible by 4, and after day 28 otherwise.
- R8: Month 12 wraps to 01 and steps the year. Year 99 wraps to 00.
- R9: With wrEn high, wrData loads the field chosen by wrSel at the next edge. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week (wrData[2:0]), 4 date, 5 month, 6 year. Other fields keep their value, and code 7 changes no field.
- R10: While freeze is high, no field changes unless it is loaded. The prescaler holds its count, so after release the second completes after the remaining cycles.
- R11: Any cycle with wrEn high restarts the prescaler. No advance occurs in that cycle, and a load works even while freeze is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Holds prescaler and all fields while high |
| wrEn | input | 1 | Host load strobe |
| wrSel | input | 3 | Field select for a load |
| wrData | input | 8 | BCD value to load |
| secOut | output | 8 | Seconds, BCD |
| minOut | output | 8 | Minutes, BCD |
| hourOut | output | 8 | Hours, BCD 00-23 |
| dowOut | output | 3 | Day of week 0-6 |
| dateOut | output | 8 | Date, BCD |
| monthOut | output | 8 | Month, BCD 01-12 |
| yearOut | output | 8 | Year, BCD 00-99 |

## Verification
The rare cases are the long carry chains: month ends, the February of a leap or common year, and the turn of year 99. Running the clock from reset would take months of simulated seconds to reach any of them. The stimulus instead loads a time just before the boundary and lets a short run of seconds cross it. Random starts bias the seconds to 50-59 and the date to the month's last days, with the divider set to four cycles so that carries happen often. The held prescaler count under freeze is checked by counting the exact remaining cycles after release.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } fieldSel_e;

  // Control to datapath strobes
  typedef struct packed {
    logic      advance;
    logic      load;
    fieldSel_e loadSel;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Year divisible by 4: (10*t + o) mod 4 == (2*t + o) mod 4
  function automatic logic isLeapYear(input logic [7:0] yearBcd);
    logic [4:0] s;
    s = {yearBcd[7:4], 1'b0} + {1'b0, yearBcd[3:0]};
    return s[1:0] == 2'd0;
  endfunction

  function automatic logic [7:0] monthLastDay(input logic [7:0] monthBcd,
                                             input logic [7:0] yearBcd);
    logic [7:0] r;
    case (monthBcd)
      8'h02:                      r = isLeapYear(yearBcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freeze,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  output calStrobe_t strobe
);

  localparam int CntW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(TICK_DIV - 1);

  logic tickDue;

  generate
    if (TICK_DIV > 1) begin : gDivide
      logic [CntW-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || wrEn) preCnt <= '0;
        else if (!freeze) preCnt <= (preCnt == CntLast) ? '0 : preCnt + 1'b1;
      end
      assign tickDue = (preCnt == CntLast);
    end else begin : gDirect
      assign tickDue = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe.advance = rstN && tickDue && !freeze && !wrEn;
    strobe.load    = rstN && wrEn;
    strobe.loadSel = fieldSel_e'(wrSel);
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  input  logic [7:0] wrData,
  output logic [7:0] secReg,
  output logic [7:0] minReg,
  output logic [7:0] hourReg,
  output logic [2:0] dowReg,
  output logic [7:0] dateReg,
  output logic [7:0] monthReg,
  output logic [7:0] yearReg
);

  logic secWrap, minWrap, hourWrap, dateWrap, monthWrap;
  logic [7:0] lastDay;

  always_comb begin
    lastDay   = monthLastDay(monthReg, yearReg);
    secWrap   = (secReg == 8'h59);
    minWrap   = secWrap && (minReg == 8'h59);
    hourWrap  = minWrap && (hourReg == 8'h23);
    dateWrap  = hourWrap && (dateReg == lastDay);
    monthWrap = dateWrap && (monthReg == 8'h12);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg   <= 8'h00;
      minReg   <= 8'h00;
      hourReg  <= 8'h00;
      dowReg   <= 3'd0;
      dateReg  <= 8'h01;
      monthReg <= 8'h01;
      yearReg  <= 8'h00;
    end else if (strobe.load) begin
      case (strobe.loadSel)
        SEL_SEC:   secReg   <= wrData;
        SEL_MIN:   minReg   <= wrData;
        SEL_HOUR:  hourReg  <= wrData;
        SEL_DOW:   dowReg   <= wrData[2:0];
        SEL_DATE:  dateReg  <= wrData;
        SEL_MONTH: monthReg <= wrData;
        SEL_YEAR:  yearReg  <= wrData;
        default: ;
      endcase
    end else if (strobe.advance) begin
      secReg <= secWrap ? 8'h00 : bcdInc(secReg);
      if (secWrap) minReg <= minWrap ? 8'h00 : bcdInc(minReg);
      if (minWrap) hourReg <= hourWrap ? 8'h00 : bcdInc(hourReg);
      if (hourWrap) begin
        dowReg  <= (dowReg >= 3'd6) ? 3'd0 : dowReg + 3'd1;
        dateReg <= dateWrap ? 8'h01 : bcdInc(dateReg);
      end
      if (dateWrap) monthReg <= monthWrap ? 8'h01 : bcdInc(monthReg);
      if (monthWrap) yearReg <= (yearReg == 8'h99) ? 8'h00 : bcdInc(yearReg);
    end
  end

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freeze,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [2:0] dowOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut
);

  calStrobe_t strobe;

  rtc_cal_ctrl #(.TICK_DIV(TICK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .freeze(freeze),
    .wrEn(wrEn), .wrSel(wrSel), .strobe(strobe)
  );

  rtc_cal_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .secReg(secOut), .minReg(minOut), .hourReg(hourOut), .dowReg(dowOut),
    .dateReg(dateOut), .monthReg(monthOut), .yearReg(yearOut)
  );

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
  input logic       clk,
  input logic       rstN,
  input logic       freeze,
  input logic       wrEn,
  input logic [2:0] wrSel,
  input logic [7:0] wrData,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [2:0] dowOut,
  input logic [7:0] dateOut,
  input logic [7:0] monthOut,
  input logic [7:0] yearOut
);

  // R10: frozen and not loaded -> every field holds
  a_r10_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !wrEn) |=> ($stable(secOut) && $stable(minOut) && $stable(hourOut)
      && $stable(dowOut) && $stable(dateOut) && $stable(monthOut) && $stable(yearOut)));

  // R9: a seconds load lands on the next edge
  a_r9_load_sec: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd0) |=> (secOut == $past(wrData)));

  // R9: a year load lands on the next edge
  a_r9_load_year: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd6) |=> (yearOut == $past(wrData)));

  // R3: minutes only move unloaded when seconds wrap to 00
  a_r3_min_carry: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(minOut) && !$past(wrEn)) |-> (secOut == 8'h00));

  // R4: date only moves unloaded at midnight, together with day of week
  a_r4_date_midnight: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dateOut) && !$past(wrEn)) |->
      (hourOut == 8'h00 && minOut == 8'h00 && secOut == 8'h00 && !$stable(dowOut)));

  // R8: year 99 leaves only to 00 when not loaded
  a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(yearOut) == 8'h99 && !$stable(yearOut) && !$past(wrEn)) |-> (yearOut == 8'h00));

endmodule

bind bcd_rtc_calendar rtc_cal_checker chk (
  .clk(clk), .rstN(rstN), .freeze(freeze), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
  .dowOut(dowOut), .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut)
);

// File: tb/bcd_rtc_calendar_test.sv
module bcd_rtc_calendar_test;

  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freeze = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] secOut, minOut, hourOut, dateOut, monthOut, yearOut;
  logic [2:0] dowOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // model state, binary
  int mS, mMi, mH, mDw, mD, mMo, mY;

  always #5 clk = ~clk;

  bcd_rtc_calendar #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .freeze(freeze), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .dowOut(dowOut), .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut)
  );

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelStep();
    mS++;
    if (mS == 60) begin
      mS = 0; mMi++;
      if (mMi == 60) begin
        mMi = 0; mH++;
        if (mH == 24) begin
          mH = 0; mDw = (mDw + 1) % 7; mD++;
          if (mD > daysIn(mMo, mY)) begin
            mD = 1; mMo++;
            if (mMo == 13) begin mMo = 1; mY = (mY + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic checkAll(input string req);
    logic [50:0] act, exp;
    act = {secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut};
    exp = {toBcd(mS), toBcd(mMi), toBcd(mH), 3'(mDw), toBcd(mD), toBcd(mMo), toBcd(mY)};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual s%h m%h h%h w%0d d%h mo%h y%h expected s%h m%h h%h w%0d d%h mo%h y%h",
        req, secOut, minOut, hourOut, dowOut, dateOut, monthOut, yearOut,
        toBcd(mS), toBcd(mMi), toBcd(mH), mDw, toBcd(mD), toBcd(mMo), toBcd(mY));
    end
  endtask

  task automatic writeField(input int sel, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = val;
  endtask

  task automatic endWrite();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input int y, input int mo, input int d, input int dw,
                         input int h, input int mi, input int s);
    writeField(0, toBcd(s));  writeField(1, toBcd(mi)); writeField(2, toBcd(h));
    writeField(3, 8'(dw));    writeField(4, toBcd(d));  writeField(5, toBcd(mo));
    writeField(6, toBcd(y));
    endWrite();
    mS = s; mMi = mi; mH = h; mDw = dw; mD = d; mMo = mo; mY = y;
  endtask

  // run n seconds from the negedge right after the last load
  task automatic runSeconds(input int n, input string req);
    repeat (n * DIV) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < n; i++) modelStep();
    checkAll(req);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mS = 0; mMi = 0; mH = 0; mDw = 0; mD = 1; mMo = 1; mY = 0;
    repeat (3) @(negedge clk);
    checkAll("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");
    // R2: first advance after DIV cycles from release
    repeat (DIV - 2) @(posedge clk);
    @(negedge clk);
    checkAll("R2 before first tick");
    @(posedge clk); @(negedge clk);
    modelStep();
    checkAll("R2 first tick");

    // R3 minute and hour carry
    setTime(23, 5, 14, 2, 10, 59, 58);
    runSeconds(3, "R3 minute-hour carry");
    // R4 + R5 midnight with day-of-week 6 -> 0
    setTime(23, 5, 14, 6, 23, 59, 59);
    runSeconds(1, "R4 R5 midnight dow wrap");
    // R6 30-day month
    setTime(23, 4, 30, 1, 23, 59, 59);
    runSeconds(1, "R6 April end");
    setTime(23, 1, 30, 1, 23, 59, 59);
    runSeconds(1, "R6 January day 31 exists");
    // R7 February common and leap
    setTime(23, 2, 28, 3, 23, 59, 59);
    runSeconds(1, "R7 Feb common year");
    setTime(24, 2, 28, 3, 23, 59, 59);
    runSeconds(1, "R7 Feb leap year to 29");
    runSeconds(86400 / 86400, "R7 second after Feb 29 start");
    setTime(0, 2, 29, 3, 23, 59, 59);
    runSeconds(1, "R7 Feb 29 year 00 ends");
    // R8 year wrap
    setTime(99, 12, 31, 4, 23, 59, 59);
    runSeconds(2, "R8 year 99 to 00");

    // R9 single-field load, code 7 ignored
    setTime(45, 7, 9, 2, 8, 30, 0);
    writeField(1, 8'h17); endWrite(); mMi = 17;
    checkAll("R9 minute load isolated");
    writeField(7, 8'h55); endWrite();
    checkAll("R9 code 7 no effect");

    // R11 load restarts prescaler
    setTime(45, 7, 9, 2, 8, 30, 0);
    repeat (DIV - 1) @(posedge clk);
    writeField(0, 8'h10); endWrite(); mS = 10;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    checkAll("R11 no tick after restart");
    @(posedge clk); @(negedge clk);
    modelStep();
    checkAll("R11 tick after full period");

    // R10 freeze holds fields and prescaler count
    setTime(12, 3, 3, 5, 1, 2, 3);
    repeat (2) @(posedge clk);
    @(negedge clk); freeze = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    checkAll("R10 frozen fields");
    // R11 load under freeze
    wrEn = 1'b1; wrSel = 3'd2; wrData = 8'h21;
    @(negedge clk); wrEn = 1'b0; mH = 21;
    checkAll("R11 load during freeze");
    // prescaler was reset by the load: needs full DIV cycles after release
    freeze = 1'b0;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    checkAll("R10 no tick before period");
    @(posedge clk); @(negedge clk);
    modelStep();
    checkAll("R10 tick after release");

    // R10 held count: freeze mid-period, no load
    setTime(12, 3, 3, 5, 1, 2, 3);
    repeat (2) @(posedge clk);
    @(negedge clk); freeze = 1'b1;
    repeat (15) @(posedge clk);
    @(negedge clk); freeze = 1'b0;
    repeat (DIV - 3) @(posedge clk);
    @(negedge clk);
    checkAll("R10 count held, not yet");
    @(posedge clk); @(negedge clk);
    modelStep();
    checkAll("R10 count held, completes");

    // random starts near boundaries
    for (int it = 0; it < 40; it++) begin
      int y, mo, d, n;
      y  = int'($urandom_range(0, 99));
      mo = int'($urandom_range(1, 12));
      d  = daysIn(mo, y) - int'($urandom_range(0, 1));
      n  = int'($urandom_range(1, 20));
      setTime(y, mo, d, int'($urandom_range(0, 6)), 23 - int'($urandom_range(0, 1)),
              59 - int'($urandom_range(0, 1)), int'($urandom_range(50, 59)));
      runSeconds(n, "R3 R4 R6 R7 R8 random boundary");
    end

    finishRun();
  end

endmodule